// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a processor bus and a serial shift engine. It holds two byte queues. The processor writes bytes into the transmit queue and the engine pops them. The engine pushes received bytes into the receive queue and the processor reads them. Both queues have the same depth, set by a parameter to 64 or 128 entries.

A control word sets two 8-bit thresholds and holds two self-clearing flush bits. A status word reports how many bytes each queue holds. Four sticky event flags sit in a write-one-to-clear status register:
- receive level reached
- transmit refill wanted
- receive overflow
- transfer finished, signalled by the engine

An enable register masks the flags into a single interrupt line. A flag whose level condition still holds after it is cleared is set again one cycle later, so software that clears a flag without servicing the queue is interrupted again.

Top module: `fifo_irq_pair`

## Requirements
- R1: During reset both counts and every status flag are zero, `irq` is low, and `ctl_rdata` reports both thresholds at three quarters of the depth (0x00300030 for depth 64).
- R2: Bytes written on `cpu_tx_we` come out on `eng_tx_data` in the order written, one per `eng_tx_pop`. The transmit count reads in `cnt_rdata[23:16]`.
- R3: Bytes pushed on `eng_rx_push` come out on `cpu_rx_data` in the order pushed, one per `cpu_rx_re`. The receive count reads in `cnt_rdata[6:0]`, saturating at 127.
- R4: A write into a full transmit queue is dropped, and the count stays at the depth.
- R5: A push into a full receive queue is dropped and sets the overflow flag, status bit 8.
- R6: Status bit 0 (receive ready) is set the cycle after the receive count is at or above the threshold in control bits 7:0.
- R7: Status bit 4 (transmit request) is set the cycle after the transmit count is at or below the threshold in control bits 23:16.
- R8: Writing a 1 to a status bit through `sta_clr_we` clears it, and writing 0 leaves it unchanged. A bit whose condition still holds is set again on the following cycle.
- R9: A pulse on `xfer_done` sets status bit 12, which stays set until it is cleared.
- R10: `irq` is high exactly when some status bit is set whose enable bit (0, 4, 8 or 12) is set. The other enable bits are not stored and read back as zero.
- R11: Writing control bit 15 empties the receive queue and writing bit 31 empties the transmit queue. Each flush bit reads back as 1 for one cycle and then as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tx_we | input | 1 | Write a byte into the transmit queue |
| cpu_tx_data | input | 8 | Byte to transmit |
| cpu_rx_re | input | 1 | Pop the head of the receive queue |
| cpu_rx_data | output | 8 | Head of the receive queue |
| ctl_we | input | 1 | Write the control word |
| ctl_wdata | input | 32 | Thresholds and flush bits |
| ctl_rdata | output | 32 | Control word readback |
| ien_we | input | 1 | Write the interrupt enables |
| ien_wdata | input | 32 | Enable bits 0, 4, 8, 12 |
| ien_rdata | output | 32 | Enable readback |
| sta_clr_we | input | 1 | Write-one-to-clear strobe for status |
| sta_clr_data | input | 32 | Status bits to clear |
| sta_rdata | output | 32 | Status flags |
| cnt_rdata | output | 32 | Fill levels of both queues |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench overfills both queues. A design that let the pointer wrap would corrupt the order that the scoreboard compares, and one that ignored the drop would miss the overflow flag. It clears flags while their level conditions still hold and samples the two cycles that follow. A design with set-over-clear priority would never show the cleared cycle, and one without a level re-set would leave the flag low. It also catches a flush bit that stays high or empties the wrong queue, and writing zeros to the clear register exposes a design that clears on any write.

// File: rtl/fip_pkg.sv
package fip_pkg;
  localparam int NFLAG     = 4;
  localparam int FLAG_RDY  = 0;
  localparam int FLAG_TREQ = 1;
  localparam int FLAG_OVF  = 2;
  localparam int FLAG_TC   = 3;

  // Map the compact flag vector to bus bit positions 0, 4, 8, 12.
  function automatic logic [31:0] flag_expand(input logic [NFLAG-1:0] f);
    return {19'b0, f[3], 3'b0, f[2], 3'b0, f[1], 3'b0, f[0]};
  endfunction

  function automatic logic [NFLAG-1:0] flag_pick(input logic [31:0] w);
    return {w[12], w[8], w[4], w[0]};
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  output logic [7:0]    rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_n  = wp_q + AW'(do_push);
    rp_n  = rp_q + AW'(do_pop);
    cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R4 / R5: a push into a full queue without a pop leaves the count unchanged
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));

  // R11: a flush leaves the queue empty
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import fip_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [7:0]    rx_lvl,
  input  logic [7:0]    tx_lvl,
  input  logic          ovf_ev,
  input  logic          done_ev,
  input  logic          ien_we,
  input  logic [31:0]   ien_wdata,
  input  logic          clr_we,
  input  logic [31:0]   clr_data,
  output logic [31:0]   sta_rdata,
  output logic [31:0]   ien_rdata,
  output logic          irq
);
  localparam int EW = ((CW > 8) ? CW : 8) + 1;

  logic [NFLAG-1:0] sta_q, sta_n, ien_q, ien_n, cond, clr;

  always_comb begin
    cond            = '0;
    cond[FLAG_RDY]  = EW'(rx_cnt) >= EW'(rx_lvl);
    cond[FLAG_TREQ] = EW'(tx_cnt) <= EW'(tx_lvl);
    cond[FLAG_OVF]  = ovf_ev;
    cond[FLAG_TC]   = done_ev;
    clr             = clr_we ? flag_pick(clr_data) : '0;
    sta_n           = (sta_q | cond) & ~clr;
    ien_n           = ien_we ? flag_pick(ien_wdata) : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      ien_q <= '0;
    end else begin
      sta_q <= sta_n;
      ien_q <= ien_n;
    end
  end

  assign sta_rdata = flag_expand(sta_q);
  assign ien_rdata = flag_expand(ien_q);
  assign irq       = |(sta_q & ien_q);

  // R8: a clear of bit 12 always wins
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[12]) |=> !sta_rdata[12]);

  // R9: the transfer-done pulse sets bit 12 unless cleared in the same cycle
  p_tc_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !(clr_we && clr_data[12])) |=> sta_rdata[12]);

  // R9: bit 12 is sticky
  p_tc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_rdata[12] && !(clr_we && clr_data[12])) |=> sta_rdata[12]);

  // R5: a dropped receive byte raises the overflow flag
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !(clr_we && clr_data[8])) |=> sta_rdata[8]);
endmodule

// File: rtl/fifo_irq_pair.sv
module fifo_irq_pair
  import fip_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_tx_we,
  input  logic [7:0]  cpu_tx_data,
  input  logic        cpu_rx_re,
  output logic [7:0]  cpu_rx_data,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        ien_we,
  input  logic [31:0] ien_wdata,
  output logic [31:0] ien_rdata,
  input  logic        sta_clr_we,
  input  logic [31:0] sta_clr_data,
  output logic [31:0] sta_rdata,
  output logic [31:0] cnt_rdata,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_avail,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        xfer_done,
  output logic        irq
);
  localparam int        CW      = $clog2(DEPTH + 1);
  localparam logic [7:0] LVL_RST = 8'(DEPTH / 4 * 3);

  logic [7:0]    rx_lvl_q, rx_lvl_n, tx_lvl_q, tx_lvl_n;
  logic          rx_fl_q, rx_fl_n, tx_fl_q, tx_fl_n;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          tx_full, tx_empty, tx_drop;
  logic          rx_full, rx_empty, rx_drop;
  logic [6:0]    rx_field;

  // Control word: thresholds hold, flush bits live for one cycle.
  always_comb begin
    rx_lvl_n = rx_lvl_q;
    tx_lvl_n = tx_lvl_q;
    rx_fl_n  = 1'b0;
    tx_fl_n  = 1'b0;
    if (ctl_we) begin
      rx_lvl_n = ctl_wdata[7:0];
      tx_lvl_n = ctl_wdata[23:16];
      rx_fl_n  = ctl_wdata[15];
      tx_fl_n  = ctl_wdata[31];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lvl_q <= LVL_RST;
      tx_lvl_q <= LVL_RST;
      rx_fl_q  <= 1'b0;
      tx_fl_q  <= 1'b0;
    end else begin
      rx_lvl_q <= rx_lvl_n;
      tx_lvl_q <= tx_lvl_n;
      rx_fl_q  <= rx_fl_n;
      tx_fl_q  <= tx_fl_n;
    end
  end

  assign ctl_rdata = {tx_fl_q, 7'b0, tx_lvl_q, rx_fl_q, 7'b0, rx_lvl_q};

  byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_fl_q),
    .push(cpu_tx_we), .wdata(cpu_tx_data),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty), .drop(tx_drop)
  );

  byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_fl_q),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(cpu_rx_re), .rdata(cpu_rx_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  assign eng_tx_avail = ~tx_empty;

  // The receive count field is 7 bits wide; deeper queues saturate it.
  generate
    if (CW > 7) begin : g_rx_sat
      assign rx_field = (rx_cnt > CW'(127)) ? 7'h7f : rx_cnt[6:0];
    end else begin : g_rx_dir
      assign rx_field = 7'(rx_cnt);
    end
  endgenerate

  assign cnt_rdata = {8'b0, 8'(tx_cnt), 9'b0, rx_field};

  irq_ctrl #(.CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_lvl(rx_lvl_q), .tx_lvl(tx_lvl_q),
    .ovf_ev(rx_drop), .done_ev(xfer_done),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .clr_we(sta_clr_we), .clr_data(sta_clr_data),
    .sta_rdata(sta_rdata), .ien_rdata(ien_rdata), .irq(irq)
  );

  // R11: a flush bit reads as set for a single cycle only
  p_flush_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[15] && !ctl_we) |=> !ctl_rdata[15]);

  // R4: the transmit drop never coincides with a non-full queue
  p_tx_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |-> (tx_cnt == CW'(DEPTH)));
endmodule

// File: tb/sim_fifo_irq_pair.sv
module sim_fifo_irq_pair;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_tx_we = 0, cpu_rx_re = 0, ctl_we = 0, ien_we = 0, sta_clr_we = 0;
  logic        eng_tx_pop = 0, eng_rx_push = 0, xfer_done = 0;
  logic [7:0]  cpu_tx_data = 0, eng_rx_data = 0;
  logic [31:0] ctl_wdata = 0, ien_wdata = 0, sta_clr_data = 0;
  logic [7:0]  cpu_rx_data, eng_tx_data;
  logic [31:0] ctl_rdata, ien_rdata, sta_rdata, cnt_rdata;
  logic        eng_tx_avail, irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  fifo_irq_pair #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_tx_we(cpu_tx_we), .cpu_tx_data(cpu_tx_data),
    .cpu_rx_re(cpu_rx_re), .cpu_rx_data(cpu_rx_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_rdata(ien_rdata),
    .sta_clr_we(sta_clr_we), .sta_clr_data(sta_clr_data), .sta_rdata(sta_rdata),
    .cnt_rdata(cnt_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .xfer_done(xfer_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drivers: each pushes the expected byte into the scoreboard queue.
  task automatic cpu_write(input logic [7:0] b, input bit expect_keep);
    @(negedge clk);
    cpu_tx_we = 1; cpu_tx_data = b;
    if (expect_keep) txq.push_back(b);
    @(negedge clk);
    cpu_tx_we = 0;
  endtask

  task automatic eng_push(input logic [7:0] b, input bit expect_keep);
    @(negedge clk);
    eng_rx_push = 1; eng_rx_data = b;
    if (expect_keep) rxq.push_back(b);
    @(negedge clk);
    eng_rx_push = 0;
  endtask

  // Monitors: pop from the design and compare with the scoreboard head.
  task automatic eng_take(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = txq.pop_front();
    chk(req, {24'b0, eng_tx_data}, {24'b0, e});
    eng_tx_pop = 1;
    @(negedge clk);
    eng_tx_pop = 0;
  endtask

  task automatic cpu_take(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = rxq.pop_front();
    chk(req, {24'b0, cpu_rx_data}, {24'b0, e});
    cpu_rx_re = 1;
    @(negedge clk);
    cpu_rx_re = 0;
  endtask

  task automatic ctl_write(input logic [31:0] w);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = w;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic ien_write(input logic [31:0] w);
    @(negedge clk);
    ien_we = 1; ien_wdata = w;
    @(negedge clk);
    ien_we = 0;
  endtask

  task automatic sta_clear(input logic [31:0] w);
    @(negedge clk);
    sta_clr_we = 1; sta_clr_data = w;
    @(negedge clk);
    sta_clr_we = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1 reset state
    idle(3);
    chk("R1 status", sta_rdata, 32'h0);
    chk("R1 counts", cnt_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ctl", ctl_rdata, 32'h0030_0030);
    rst_n = 1;
    idle(2);

    // R7: empty transmit queue is at or below 48
    chk("R7 treq empty", {31'b0, sta_rdata[4]}, 32'h1);

    // R2: short transfer order and count
    for (int i = 0; i < 5; i++) cpu_write(8'hA0 + 8'(i), 1);
    chk("R2 tx count", {24'b0, cnt_rdata[23:16]}, 32'd5);
    for (int i = 0; i < 5; i++) eng_take("R2 tx order");

    // R4: overfill the transmit queue
    for (int i = 0; i < DEPTH + 2; i++) cpu_write(8'(i * 7 + 3), i < DEPTH);
    chk("R4 tx full count", {24'b0, cnt_rdata[23:16]}, DEPTH);
    sta_clear(32'h10);
    idle(1);
    chk("R7 treq low above level", {31'b0, sta_rdata[4]}, 32'h0);
    for (int i = 0; i < DEPTH; i++) eng_take("R4 tx order after drop");
    chk("R2 tx drained", {31'b0, eng_tx_avail}, 32'h0);

    // R8: clear while condition holds, then re-set one cycle later
    sta_clear(32'h10);
    chk("R8 cleared", {31'b0, sta_rdata[4]}, 32'h0);
    @(negedge clk);
    chk("R8 re-set", {31'b0, sta_rdata[4]}, 32'h1);

    // R6 / R3: receive threshold 4
    ctl_write(32'h0030_0004);
    for (int i = 0; i < 3; i++) eng_push(8'h50 + 8'(i), 1);
    idle(1);
    chk("R6 below level", {31'b0, sta_rdata[0]}, 32'h0);
    eng_push(8'h53, 1);
    idle(1);
    chk("R6 at level", {31'b0, sta_rdata[0]}, 32'h1);
    chk("R3 rx count", {25'b0, cnt_rdata[6:0]}, 32'd4);
    for (int i = 0; i < 4; i++) cpu_take("R3 rx order");
    sta_clear(32'h1);
    idle(1);
    chk("R6 stays clear", {31'b0, sta_rdata[0]}, 32'h0);

    // R5: overfill the receive queue
    for (int i = 0; i < DEPTH + 2; i++) eng_push(8'(i * 5 + 1), i < DEPTH);
    idle(1);
    chk("R5 rx full count", {25'b0, cnt_rdata[6:0]}, DEPTH);
    chk("R5 overflow flag", {31'b0, sta_rdata[8]}, 32'h1);
    sta_clear(32'h100);
    idle(1);
    chk("R5 overflow cleared", {31'b0, sta_rdata[8]}, 32'h0);
    for (int i = 0; i < DEPTH; i++) cpu_take("R5 rx order after drop");

    // R9: transfer-done flag
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    chk("R9 tc set", {31'b0, sta_rdata[12]}, 32'h1);
    sta_clear(32'h0);
    idle(1);
    chk("R8 zero write no effect", {31'b0, sta_rdata[12]}, 32'h1);
    sta_clear(32'h1000);
    chk("R9 tc cleared", {31'b0, sta_rdata[12]}, 32'h0);

    // R10: interrupt masking
    sta_clear(32'hFFFF_FFFF);
    ien_write(32'hFFFF_FFFF);
    chk("R10 enable readback", ien_rdata, 32'h0000_1111);
    chk("R10 irq on treq", {31'b0, irq}, 32'h1);
    ien_write(32'h0);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    ien_write(32'h1000);
    chk("R10 irq no tc", {31'b0, irq}, 32'h0);
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    chk("R10 irq on tc", {31'b0, irq}, 32'h1);
    sta_clear(32'h1000);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);

    // R11: flushes
    for (int i = 0; i < 3; i++) cpu_write(8'h11, 0);
    for (int i = 0; i < 3; i++) eng_push(8'h22, 0);
    ctl_write(32'h0030_8004);
    chk("R11 rx flush bit visible", {31'b0, ctl_rdata[15]}, 32'h1);
    @(negedge clk);
    chk("R11 rx flush self-clear", {31'b0, ctl_rdata[15]}, 32'h0);
    chk("R11 rx emptied tx kept", cnt_rdata, 32'h0003_0000);
    ctl_write(32'h8030_0004);
    @(negedge clk);
    chk("R11 tx emptied", cnt_rdata, 32'h0);
    chk("R11 ctl after flush", ctl_rdata, 32'h0030_0004);

    summary();
  end
endmodule